// File: doc/BRIEF.md
# Serial Port Host Register Front End

This block is the register face of a serial port. A host reaches it over a small byte-wide bus with an address, a write strobe and a read strobe. Behind the bus sit two mode registers that share one address, plus a status view, an interrupt status view, an interrupt mask and a command register. The command register drives the enable state of the transmitter and the receiver. The serializer itself is outside the block: it delivers received bytes and break events on a byte-valid input, and it takes transmit bytes from a byte-valid output.

A one-byte holding buffer stages transmit data until the transmitter is enabled. A small receive queue holds incoming bytes in arrival order until the host reads them. One registered interrupt line is raised whenever an unmasked interrupt status bit is set. The receive interrupt can be taken either from "data available" or from "queue full", and a mode bit picks which.

Register offsets, with each register named by its read/write use:

- 0x00: mode register, through the pointer.
- 0x04: status on read; writes have no effect.
- 0x08: command on write.
- 0x0C: receive queue on read, transmit buffer on write.
- 0x14: interrupt status on read, mask on write.
- 0x18: divisor high byte, read only.
- 0x1C: divisor low byte, read only.

Top module: `uart_host_regs`

## Requirements
- R1: After reset, status reads 0x08, interrupt status reads 0x00, the mask is 0x00, `irq` is low, `tx_valid` is low, the mode pointer selects mode register 1, and both mode registers hold 0x00.
- R2: A write to offset 0x00 stores into the register that the pointer selects, then moves the pointer to mode register 2. A read of offset 0x00 returns the selected register. A command whose bits[6:4] equal 1 moves the pointer back to mode register 1.
- R3: Status bits are: bit0 receive data available, bit1 queue full, bit2 transmitter ready, bit3 transmit buffer empty. Bits 7:4 read 0. Writes to offset 0x04 change nothing.
- R4: Interrupt status bits are: bit0 transmit, bit1 receive, bit2 break seen. Bits 7:3 read 0. The transmit bit equals transmitter ready. `irq` equals the OR of (interrupt status AND mask), and it changes on the clock edge that ends the strobe or event causing the change.
- R5: When mode register 1 bit6 is 0, the receive interrupt bit follows "data available". When that bit is 1, it follows "queue full".
- R6: A write to offset 0x0C loads the transmit buffer and clears "buffer empty". If the transmitter is enabled, the byte is driven on `tx_data` with a one-cycle `tx_valid` pulse in the cycle after the write, and "buffer empty" is set again. A byte held while the transmitter is disabled is sent when the transmitter is enabled.
- R7: Command bits[3:2] set to 1 enable the transmitter and set to 2 disable it. Command bits[1:0] set to 1 enable the receiver and set to 2 disable it. The value 3 in either field is ignored. Transmitter ready equals transmitter enabled.
- R8: Command bits[6:4] set to 2 disable the receiver and empty the queue. Set to 3, they disable the transmitter and discard any held byte, setting "buffer empty". Set to 5, they clear the break-seen interrupt bit. Other values change nothing.
- R9: The queue holds 4 bytes. A read of offset 0x0C returns the oldest byte and removes it. A read of an empty queue returns 0x00. "Data available" is set while the queue holds a byte, and "queue full" is set while it holds 4.
- R10: A received byte is dropped when the receiver is disabled or the queue is full.
- R11: A break event sets the break-seen bit and queues a 0x00 byte whether or not the receiver is enabled. When the queue is full, the 0x00 replaces the newest entry.
- R12: Offsets 0x18 and 0x1C read the parameters `DIV_HI` and `DIV_LO`. Every other offset without a read function, including 0x08 and 0x10, reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid during the read strobe |
| rx_valid | input | 1 | Received byte present this cycle |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Break event this cycle |
| tx_valid | output | 1 | Transmit byte present this cycle |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Registered interrupt request |

## Verification
Some rules are checked on every cycle. The queue count never exceeds its depth. An enabled transmitter never leaves a byte held. A transmit pulse only appears while the transmitter is enabled. The interrupt line always matches the masked interrupt status. A disabled receiver with no break never grows the queue. A break always leaves the break-seen bit set. A read of a non-empty queue shrinks it by one. Only the bench's scenarios can show the rest: the contents and ordering of the queue, the break overwrite of the newest entry, the mode-pointer walk, the held-byte release on enable, the discard on transmitter reset, and the exact read values at each offset.

// File: rtl/uart_host_regs.sv
module uart_host_regs #(
  parameter int AW = 5,
  parameter int DEPTH = 4,
  parameter logic [7:0] DIV_HI = 8'h12,
  parameter logic [7:0] DIV_LO = 8'h34
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_break,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          irq
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [AW-1:0] A_MODE = AW'(8'h00);
  localparam logic [AW-1:0] A_STAT = AW'(8'h04);
  localparam logic [AW-1:0] A_CMD  = AW'(8'h08);
  localparam logic [AW-1:0] A_DATA = AW'(8'h0C);
  localparam logic [AW-1:0] A_INT  = AW'(8'h14);
  localparam logic [AW-1:0] A_DIVH = AW'(8'h18);
  localparam logic [AW-1:0] A_DIVL = AW'(8'h1C);

  logic [7:0]    mode1, mode2, int_mask, tx_hold;
  logic          mode_sel, tx_on, rx_on, tx_empty, db_flag;
  logic [7:0]    fifo [DEPTH];
  logic [CW-1:0] cnt;

  logic [7:0]    n_mode1, n_mode2, n_mask, n_hold;
  logic          n_sel, n_tx_on, n_rx_on, n_empty, n_db, n_send;
  logic [7:0]    n_fifo [DEPTH];
  logic [CW-1:0] n_cnt;
  logic          n_rxint, n_irq;

  wire rx_ready  = (cnt != '0);
  wire fifo_full = (cnt == FULL);
  wire rx_int    = mode1[6] ? fifo_full : rx_ready;
  wire [7:0] stat    = {4'b0, tx_empty, tx_on, fifo_full, rx_ready};
  wire [7:0] isr_now = {5'b0, db_flag, rx_int, tx_on};
  wire wr_cmd  = bus_wr && bus_addr == A_CMD;
  wire [2:0] misc = bus_wdata[6:4];
  wire accept  = rx_valid && !rx_break && rx_on && !fifo_full;

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_rd) begin
      case (bus_addr)
        A_MODE: bus_rdata = mode_sel ? mode2 : mode1;
        A_STAT: bus_rdata = stat;
        A_DATA: bus_rdata = rx_ready ? fifo[0] : 8'h00;
        A_INT:  bus_rdata = isr_now;
        A_DIVH: bus_rdata = DIV_HI;
        A_DIVL: bus_rdata = DIV_LO;
        default: bus_rdata = 8'h00;
      endcase
    end
  end

  always_comb begin
    n_mode1 = mode1; n_mode2 = mode2; n_sel = mode_sel; n_mask = int_mask;
    n_hold = tx_hold; n_tx_on = tx_on; n_rx_on = rx_on; n_empty = tx_empty;
    n_db = db_flag; n_cnt = cnt; n_send = 1'b0;
    for (int i = 0; i < DEPTH; i++) n_fifo[i] = fifo[i];

    if (bus_rd && bus_addr == A_DATA && rx_ready) begin
      for (int i = 0; i < DEPTH - 1; i++) n_fifo[i] = fifo[i + 1];
      n_cnt = cnt - 1'b1;
    end

    if (bus_wr) begin
      case (bus_addr)
        A_MODE: begin
          if (mode_sel) n_mode2 = bus_wdata; else n_mode1 = bus_wdata;
          n_sel = 1'b1;
        end
        A_DATA: begin
          n_hold = bus_wdata;
          n_empty = 1'b0;
        end
        A_INT: n_mask = bus_wdata;
        default: ;
      endcase
    end

    if (wr_cmd) begin
      case (misc)
        3'd1: n_sel = 1'b0;
        3'd2: begin n_rx_on = 1'b0; n_cnt = '0; end
        3'd3: begin n_tx_on = 1'b0; n_empty = 1'b1; end
        3'd5: n_db = 1'b0;
        default: ;
      endcase
      case (bus_wdata[3:2])
        2'd1: n_tx_on = 1'b1;
        2'd2: n_tx_on = 1'b0;
        default: ;
      endcase
      case (bus_wdata[1:0])
        2'd1: n_rx_on = 1'b1;
        2'd2: n_rx_on = 1'b0;
        default: ;
      endcase
    end

    if (n_tx_on && !n_empty) begin
      n_send = 1'b1;
      n_empty = 1'b1;
    end

    if (rx_break) begin
      n_db = 1'b1;
      if (n_cnt == FULL) n_fifo[DEPTH-1] = 8'h00;
      else begin
        for (int i = 0; i < DEPTH; i++)
          if (CW'(i) == n_cnt) n_fifo[i] = 8'h00;
        n_cnt = n_cnt + 1'b1;
      end
    end else if (accept && n_cnt != FULL) begin
      for (int i = 0; i < DEPTH; i++)
        if (CW'(i) == n_cnt) n_fifo[i] = rx_data;
      n_cnt = n_cnt + 1'b1;
    end

    n_rxint = n_mode1[6] ? (n_cnt == FULL) : (n_cnt != '0);
    n_irq = |({5'b0, n_db, n_rxint, n_tx_on} & n_mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode1 <= '0; mode2 <= '0; mode_sel <= 1'b0; int_mask <= '0;
      tx_hold <= '0; tx_on <= 1'b0; rx_on <= 1'b0; tx_empty <= 1'b1;
      db_flag <= 1'b0; cnt <= '0; irq <= 1'b0;
      tx_valid <= 1'b0; tx_data <= '0;
      for (int i = 0; i < DEPTH; i++) fifo[i] <= '0;
    end else begin
      mode1 <= n_mode1; mode2 <= n_mode2; mode_sel <= n_sel; int_mask <= n_mask;
      tx_hold <= n_hold; tx_on <= n_tx_on; rx_on <= n_rx_on; tx_empty <= n_empty;
      db_flag <= n_db; cnt <= n_cnt; irq <= n_irq;
      tx_valid <= n_send;
      if (n_send) tx_data <= n_hold;
      for (int i = 0; i < DEPTH; i++) fifo[i] <= n_fifo[i];
    end
  end

  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);
  a_r9_read_pops: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_DATA && rx_ready && !rx_valid && !rx_break)
      |=> cnt == $past(cnt) - 1'b1);
  a_r6_no_stalled_byte: assert property (@(posedge clk) disable iff (!rst_n)
    tx_on |-> tx_empty);
  a_r6_send_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_on);
  a_r4_irq_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(isr_now & int_mask));
  a_r10_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_on && !rx_break) |=> cnt <= $past(cnt));
  a_r11_break_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rx_break |=> db_flag);
endmodule

// File: tb/tb_uart_host_regs.sv
`timescale 1ns/1ps
module tb_uart_host_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       rx_valid = 1'b0, rx_break = 1'b0;
  logic [7:0] rx_data = '0;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       irq;
  int checks = 0, fails = 0, tx_count = 0;
  logic [7:0] tx_last = '0;

  always #2.5 clk = ~clk;

  uart_host_regs dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_break(rx_break), .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq));

  always @(posedge clk) begin
    #1;
    if (tx_valid) begin tx_count++; tx_last = tx_data; end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a[4:0]; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a[4:0];
    #1 check(tag, bus_rdata, exp);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk); rx_valid = 1'b1; rx_data = d;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic brk();
    @(negedge clk); rx_break = 1'b1;
    @(negedge clk); rx_break = 1'b0;
  endtask

  // op(2) req(4) addr(8) wdata(8) expected(8); op 0 = write, 1 = read and compare
  localparam int NV = 20;
  localparam logic [29:0] VEC [NV] = '{
    {2'd1, 4'd1,  8'h04, 8'h00, 8'h08},  // R1 status after reset
    {2'd1, 4'd1,  8'h14, 8'h00, 8'h00},  // R1 interrupt status
    {2'd1, 4'd1,  8'h00, 8'h00, 8'h00},  // R1 mode 1
    {2'd0, 4'd2,  8'h00, 8'h40, 8'h00},  // R2 write mode 1
    {2'd0, 4'd2,  8'h00, 8'h5A, 8'h00},  // R2 write mode 2
    {2'd1, 4'd2,  8'h00, 8'h00, 8'h5A},  // R2 pointer on mode 2
    {2'd0, 4'd2,  8'h08, 8'h10, 8'h00},  // R2 pointer back
    {2'd1, 4'd2,  8'h00, 8'h00, 8'h40},  // R2 mode 1 again
    {2'd0, 4'd3,  8'h04, 8'hFF, 8'h00},  // R3 status write
    {2'd1, 4'd3,  8'h04, 8'h00, 8'h08},  // R3 unchanged
    {2'd0, 4'd7,  8'h08, 8'h05, 8'h00},  // R7 enable both
    {2'd1, 4'd7,  8'h04, 8'h00, 8'h0C},  // R7 ready + empty
    {2'd1, 4'd4,  8'h14, 8'h00, 8'h01},  // R4 transmit interrupt bit
    {2'd1, 4'd12, 8'h18, 8'h00, 8'h12},  // R12 divisor high
    {2'd1, 4'd12, 8'h1C, 8'h00, 8'h34},  // R12 divisor low
    {2'd1, 4'd12, 8'h10, 8'h00, 8'h00},  // R12 unused read
    {2'd0, 4'd7,  8'h08, 8'h0F, 8'h00},  // R7 reserved fields
    {2'd1, 4'd7,  8'h04, 8'h00, 8'h0C},  // R7 still enabled
    {2'd0, 4'd7,  8'h08, 8'h0A, 8'h00},  // R7 disable both
    {2'd1, 4'd7,  8'h04, 8'h00, 8'h08}   // R7 disabled
  };

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    check("R1 irq", {7'b0, irq}, 8'h00);
    check("R1 tx_valid", {7'b0, tx_valid}, 8'h00);
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][29:28] == 2'd0) wr(VEC[i][23:16], VEC[i][15:8]);
      else rd(VEC[i][23:16], VEC[i][7:0], $sformatf("R%0d vec%0d", VEC[i][27:24], i));
    end

    do_reset();
    rd(8'h00, 8'h00, "R1 mode cleared");
    rd(8'h08, 8'h00, "R12 command reads zero");
    // R6 transmit path
    wr(8'h08, 8'h04);
    wr(8'h0C, 8'hA5);
    check("R6 sent count", 8'(tx_count), 8'd1);
    check("R6 sent data", tx_last, 8'hA5);
    rd(8'h04, 8'h0C, "R6 empty again");
    wr(8'h08, 8'h08);
    wr(8'h0C, 8'h3C);
    rd(8'h04, 8'h00, "R6 held byte");
    check("R6 nothing sent", 8'(tx_count), 8'd1);
    wr(8'h08, 8'h04);
    check("R6 release count", 8'(tx_count), 8'd2);
    check("R6 release data", tx_last, 8'h3C);
    rd(8'h04, 8'h0C, "R6 status after release");
    // R8 transmitter reset discards
    wr(8'h08, 8'h08);
    wr(8'h0C, 8'h77);
    wr(8'h08, 8'h30);
    rd(8'h04, 8'h08, "R8 tx reset status");
    wr(8'h08, 8'h04);
    check("R8 discarded byte", 8'(tx_count), 8'd2);

    // R10 / R9 receive queue
    push(8'h11);
    rd(8'h04, 8'h0C, "R10 disabled drop");
    wr(8'h08, 8'h01);
    push(8'h21); push(8'h22); push(8'h23); push(8'h24);
    rd(8'h04, 8'h0F, "R9 full status");
    push(8'h25);
    rd(8'h0C, 8'h21, "R9 oldest first");
    rd(8'h04, 8'h0D, "R9 not full after pop");
    rd(8'h0C, 8'h22, "R9 order 2");
    rd(8'h0C, 8'h23, "R9 order 3");
    rd(8'h0C, 8'h24, "R10 full drop kept last");
    rd(8'h04, 8'h0C, "R9 empty status");
    rd(8'h0C, 8'h00, "R9 empty read");

    // R4 / R5 interrupt source
    wr(8'h14, 8'h02);
    check("R4 masked tx", {7'b0, irq}, 8'h00);
    push(8'h51);
    check("R5 ready source irq", {7'b0, irq}, 8'h01);
    rd(8'h0C, 8'h51, "R9 single byte");
    check("R4 irq drops", {7'b0, irq}, 8'h00);
    wr(8'h08, 8'h10);
    wr(8'h00, 8'h40);
    push(8'h61); push(8'h62); push(8'h63);
    check("R5 full source no irq", {7'b0, irq}, 8'h00);
    push(8'h64);
    check("R5 full source irq", {7'b0, irq}, 8'h01);
    rd(8'h14, 8'h03, "R4 isr tx+rx");
    rd(8'h0C, 8'h61, "R9 pop");
    check("R5 irq clears", {7'b0, irq}, 8'h00);
    wr(8'h08, 8'h20);
    rd(8'h04, 8'h0C, "R8 rx reset flush");
    push(8'h71);
    rd(8'h04, 8'h0C, "R8 rx disabled after reset");

    // R11 break handling
    wr(8'h14, 8'h04);
    brk();
    check("R11 break irq", {7'b0, irq}, 8'h01);
    rd(8'h14, 8'h05, "R11 break bit");
    rd(8'h04, 8'h0D, "R11 zero queued");
    rd(8'h0C, 8'h00, "R11 zero byte");
    wr(8'h08, 8'h01);
    push(8'h31); push(8'h32); push(8'h33); push(8'h34);
    brk();
    rd(8'h0C, 8'h31, "R11 keep 1");
    rd(8'h0C, 8'h32, "R11 keep 2");
    rd(8'h0C, 8'h33, "R11 keep 3");
    rd(8'h0C, 8'h00, "R11 overwrite last");
    wr(8'h08, 8'h50);
    rd(8'h14, 8'h01, "R8 break cleared");
    check("R8 irq after clear", {7'b0, irq}, 8'h00);

    do_reset();
    rd(8'h04, 8'h08, "R1 status after reset");
    rd(8'h14, 8'h00, "R1 isr after reset");
    check("R1 irq after reset", {7'b0, irq}, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule